// File: doc/BRIEF.md
# Raster Printer-Plotter DMA Controller

This block sits on a register bus as a slave. It owns a small DMA read engine that feeds bytes from system memory to a raster printer/plotter. Software picks print, plot or combined print-plot operation through two control/status words. It starts a transfer by writing a byte count. The engine then fetches 16-bit words, hands them out one byte at a time on a ready/strobe port and raises an interrupt pulse when it finishes or gives up.

Four one-shot device commands (clear, end-of-transmission, form feed, terminate) go out as single-cycle pulses. Each command stays visible in the status word until the device reports that it is done. A soft-reset bit in the plot status word abandons any operation in progress.

Top module: `rpp_dma_ctrl`

## Requirements
- R1: After `rst_n` is released, the following hold: both byte counters read 0, `mem_req` and `irq` are low, and each status word reads 0x0080 (only ready set).
- R2: A nonzero write to the plot count (offset 0) starts a transfer in plot mode, and `dev_mode` is 1. A nonzero write to the print count (offset 2) starts print mode, with `dev_mode` 0, or combined mode, with `dev_mode` 2, when plot status bit 0 is set. Status bit 13 (active) stays 1 and bit 7 (ready) stays 0 until the count reaches zero. A count write of zero, or one made while a transfer or a command is in progress, changes nothing.
- R3: The memory word address is {extension[5:4], base[15:0]}. After each word is fetched, the address advances by 2, and the carry passes into extension bits 5:4. The other extension bits are kept. Base (offset 3) and extension (offset 1) read back the advanced address.
- R4: Each word yields its low byte and then its high byte. An odd count ends after the low byte of the last word, so exactly ceil(count/2) words are read.
- R5: Each byte appears on `dev_data` together with a one-cycle `dev_strobe`. The strobe is issued only after `dev_ready` was sampled high. No byte is lost or repeated while the device stalls.
- R6: When a transfer's count reaches zero, `irq` pulses for one cycle, but only if both bit 6 (interrupt enable) and bit 14 (completion interrupt enable) are set in the status word of that transfer's mode. Plot mode uses offset 4. Print and combined modes use offset 6.
- R7: If `mem_gnt` has not arrived after 64 cycles of `mem_req`, the following happen: status bit 15 (error) is set, the transfer is abandoned (active clears, ready returns) and `irq` pulses if bit 6 of the mode's status word is set. A later count write clears the error.
- R8: Writing a command bit to the plot status word (offset 4) while ready is set sends a one-cycle pulse on `dev_cmd`. The bit positions map as follows: status bit 2 clear → `dev_cmd[0]`, bit 3 end-of-transmission → `dev_cmd[1]`, bit 4 form feed → `dev_cmd[2]`, bit 5 terminate → `dev_cmd[3]`. The status bit reads 1 and ready reads 0 until `dev_cmd_done` is seen. The bit then clears, and `irq` pulses if plot bit 6 is set.
- R9: If one write sets several command bits, only the lowest-numbered bit is accepted. A command written while a transfer or another command is in progress is dropped, with no pulse and no readback.
- R10: Writing plot status bit 1 resets the controller: it clears both counters, the error flag, active and any pending command, stops the memory request and leaves the status reading ready.
- R11: The plot data buffer (offset 5) holds the last byte sent in plot mode. The print data buffer (offset 7) holds the last byte sent in print or combined mode. Bus writes to either buffer have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register word offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on `reg_addr`) |
| mem_req | output | 1 | Memory read request, held until granted |
| mem_addr | output | 18 | Memory byte address of the requested word |
| mem_gnt | input | 1 | One-cycle grant carrying `mem_rdata` |
| mem_rdata | input | 16 | Memory read data |
| dev_ready | input | 1 | Device can accept a byte |
| dev_strobe | output | 1 | One-cycle byte strobe |
| dev_data | output | 8 | Output byte |
| dev_mode | output | 2 | 0 print, 1 plot, 2 combined |
| dev_cmd | output | 4 | One-shot command pulses |
| dev_cmd_done | input | 1 | Device finished the pending command |
| irq | output | 1 | Interrupt request pulse |

## Verification
Two cases are hard to reach: commands and count writes that arrive while a transfer is mid-flight, and a soft reset that lands in the middle of one. The bench holds `dev_ready` low right after a transfer starts. This parks the engine with a fetched word and no byte sent, so the ignored writes and the abort can be tried in a known state. The fetch timeout is reached by switching the bench memory into a mode where it never grants. A second pass then checks that a reset clears the error.

// File: rtl/rpp_pkg.sv
package rpp_pkg;

  localparam int REG_W  = 16;
  localparam int ADDR_W = 18;

  localparam logic [2:0] OFS_PLOT_CNT  = 3'd0;
  localparam logic [2:0] OFS_ADDR_EXT  = 3'd1;
  localparam logic [2:0] OFS_PRINT_CNT = 3'd2;
  localparam logic [2:0] OFS_BASE      = 3'd3;
  localparam logic [2:0] OFS_PLOT_CSR  = 3'd4;
  localparam logic [2:0] OFS_PLOT_BUF  = 3'd5;
  localparam logic [2:0] OFS_PRINT_CSR = 3'd6;
  localparam logic [2:0] OFS_PRINT_BUF = 3'd7;

  typedef enum logic [1:0] {
    MODE_PRINT = 2'd0,
    MODE_PLOT  = 2'd1,
    MODE_BOTH  = 2'd2
  } mode_t;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_FETCH,
    ENG_LO,
    ENG_HI
  } eng_st_t;

  function automatic logic [ADDR_W-1:0] addr_join(input logic [1:0] hi, input logic [15:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(2);
  endfunction

  function automatic logic [3:0] lowest_set(input logic [3:0] b);
    return b & (~b + 4'd1);
  endfunction

endpackage

// File: rtl/rpp_dma_engine.sv
module rpp_dma_engine
  import rpp_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int TMO_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ld_base,
  input  logic              ld_ext,
  input  logic              ld_plot,
  input  logic              ld_print,
  input  logic [15:0]       wdata,
  input  logic              spp_sel,
  input  logic              cmd_busy,
  input  logic              mem_gnt,
  input  logic [15:0]       mem_rdata,
  input  logic              dev_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              dev_strobe,
  output logic [7:0]        dev_data,
  output logic [15:0]       base_q,
  output logic [15:0]       ext_q,
  output logic [CNT_W-1:0]  cnt_plot,
  output logic [CNT_W-1:0]  cnt_print,
  output logic              active,
  output logic              err,
  output mode_t             mode,
  output logic              xfer_done,
  output logic              xfer_err
);

  localparam int TW = $clog2(TMO_CYC);

  eng_st_t          state;
  logic [TW-1:0]    wait_q;
  logic [15:0]      word_q;
  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] ld_val;
  logic             start;
  logic             last_byte;
  logic [ADDR_W-1:0] next_addr;

  assign ld_val    = wdata[CNT_W-1:0];
  assign cur_cnt   = (mode == MODE_PLOT) ? cnt_plot : cnt_print;
  assign last_byte = (cur_cnt == CNT_W'(1));
  assign start     = (ld_plot || ld_print) && (state == ENG_IDLE) && !cmd_busy
                     && (ld_val != '0);
  assign mem_addr  = addr_join(ext_q[5:4], base_q);
  assign next_addr = addr_step(mem_addr);
  assign mem_req   = (state == ENG_FETCH);
  assign active    = (state != ENG_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ENG_IDLE;
      wait_q     <= '0;
      word_q     <= '0;
      base_q     <= '0;
      ext_q      <= '0;
      cnt_plot   <= '0;
      cnt_print  <= '0;
      err        <= 1'b0;
      mode       <= MODE_PRINT;
      dev_strobe <= 1'b0;
      dev_data   <= '0;
      xfer_done  <= 1'b0;
      xfer_err   <= 1'b0;
    end else begin
      dev_strobe <= 1'b0;
      xfer_done  <= 1'b0;
      xfer_err   <= 1'b0;
      if (soft_rst) begin
        state     <= ENG_IDLE;
        wait_q    <= '0;
        cnt_plot  <= '0;
        cnt_print <= '0;
        err       <= 1'b0;
      end else begin
        case (state)
          ENG_IDLE: begin
            if (ld_base) base_q <= wdata;
            if (ld_ext)  ext_q  <= wdata;
            if (start) begin
              if (ld_plot) begin
                cnt_plot <= ld_val;
                mode     <= MODE_PLOT;
              end else begin
                cnt_print <= ld_val;
                mode      <= spp_sel ? MODE_BOTH : MODE_PRINT;
              end
              err    <= 1'b0;
              wait_q <= '0;
              state  <= ENG_FETCH;
            end
          end
          ENG_FETCH: begin
            if (mem_gnt) begin
              word_q     <= mem_rdata;
              base_q     <= next_addr[15:0];
              ext_q[5:4] <= next_addr[17:16];
              state      <= ENG_LO;
            end else if (wait_q == TW'(TMO_CYC - 1)) begin
              err      <= 1'b1;
              xfer_err <= 1'b1;
              state    <= ENG_IDLE;
            end else begin
              wait_q <= wait_q + TW'(1);
            end
          end
          ENG_LO, ENG_HI: begin
            if (dev_ready) begin
              dev_strobe <= 1'b1;
              dev_data   <= (state == ENG_LO) ? word_q[7:0] : word_q[15:8];
              if (mode == MODE_PLOT) cnt_plot  <= cnt_plot - CNT_W'(1);
              else                   cnt_print <= cnt_print - CNT_W'(1);
              if (last_byte) begin
                xfer_done <= 1'b1;
                state     <= ENG_IDLE;
              end else if (state == ENG_LO) begin
                state <= ENG_HI;
              end else begin
                wait_q <= '0;
                state  <= ENG_FETCH;
              end
            end
          end
          default: state <= ENG_IDLE;
        endcase
      end
    end
  end

  // checker-side run length of an ungranted request
  logic [TW:0] chk_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                  chk_run <= '0;
    else if (mem_req && !mem_gnt) chk_run <= chk_run + (TW+1)'(1);
    else                         chk_run <= '0;
  end

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !soft_rst) |=> $stable(mem_addr));

  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_run <= (TW+1)'(TMO_CYC));

  p_strobe_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe |-> $past(dev_ready));

  p_done_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (cur_cnt == '0) && !active);

endmodule

// File: rtl/rpp_cmd_unit.sv
module rpp_cmd_unit
  import rpp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cmd_wr,
  input  logic [3:0] cmd_bits,
  input  logic       allow,
  input  logic       dev_cmd_done,
  output logic [3:0] pend,
  output logic [3:0] dev_cmd,
  output logic       busy,
  output logic       cmd_done
);

  logic       accept;
  logic [3:0] pick;

  assign pick   = lowest_set(cmd_bits);
  assign busy   = (pend != 4'd0);
  assign accept = cmd_wr && !soft_rst && allow && !busy && (cmd_bits != 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      dev_cmd  <= '0;
      cmd_done <= 1'b0;
    end else begin
      dev_cmd  <= '0;
      cmd_done <= 1'b0;
      if (soft_rst) begin
        pend <= '0;
      end else if (accept) begin
        pend    <= pick;
        dev_cmd <= pick;
      end else if (busy && dev_cmd_done) begin
        pend     <= '0;
        cmd_done <= 1'b1;
      end
    end
  end

  p_pend_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pend));

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_cmd != 4'd0) |=> (dev_cmd == 4'd0));

  p_pulse_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_cmd != 4'd0) |-> (dev_cmd == pend));

  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> (pend == 4'd0));

endmodule

// File: rtl/rpp_regfile.sv
module rpp_regfile
  import rpp_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       rd_sel,
  input  logic             wr_plot_csr,
  input  logic             wr_print_csr,
  input  logic             w_tcie,
  input  logic             w_ie,
  input  logic             w_spp,
  input  logic             dev_strobe,
  input  logic [7:0]       dev_data,
  input  mode_t            mode,
  input  logic [CNT_W-1:0] cnt_plot,
  input  logic [CNT_W-1:0] cnt_print,
  input  logic [15:0]      base_q,
  input  logic [15:0]      ext_q,
  input  logic             err,
  input  logic             active,
  input  logic             ready,
  input  logic [3:0]       cmd_pend,
  input  logic             xfer_done,
  input  logic             xfer_err,
  input  logic             cmd_done,
  output logic             spp_sel,
  output logic             irq,
  output logic [15:0]      rdata
);

  logic       plot_ie, plot_tcie, print_ie, print_tcie;
  logic [7:0] plot_buf, print_buf;
  logic       ie_m, tcie_m;

  assign spp_sel = 1'b0 | plot_spp_q;
  logic plot_spp_q;

  assign ie_m   = (mode == MODE_PLOT) ? plot_ie   : print_ie;
  assign tcie_m = (mode == MODE_PLOT) ? plot_tcie : print_tcie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plot_ie    <= 1'b0;
      plot_tcie  <= 1'b0;
      plot_spp_q <= 1'b0;
      print_ie   <= 1'b0;
      print_tcie <= 1'b0;
      plot_buf   <= '0;
      print_buf  <= '0;
      irq        <= 1'b0;
    end else begin
      if (wr_plot_csr) begin
        plot_ie    <= w_ie;
        plot_tcie  <= w_tcie;
        plot_spp_q <= w_spp;
      end
      if (wr_print_csr) begin
        print_ie   <= w_ie;
        print_tcie <= w_tcie;
      end
      if (dev_strobe) begin
        if (mode == MODE_PLOT) plot_buf  <= dev_data;
        else                   print_buf <= dev_data;
      end
      irq <= (xfer_done && ie_m && tcie_m) || (xfer_err && ie_m) || (cmd_done && plot_ie);
    end
  end

  always_comb begin
    case (rd_sel)
      OFS_PLOT_CNT:  rdata = 16'(cnt_plot);
      OFS_ADDR_EXT:  rdata = ext_q;
      OFS_PRINT_CNT: rdata = 16'(cnt_print);
      OFS_BASE:      rdata = base_q;
      OFS_PLOT_CSR:  rdata = {err, plot_tcie, active, 5'd0, ready, plot_ie,
                             cmd_pend, 1'b0, plot_spp_q};
      OFS_PLOT_BUF:  rdata = {8'd0, plot_buf};
      OFS_PRINT_CSR: rdata = {err, print_tcie, active, 5'd0, ready, print_ie, 6'd0};
      default:       rdata = {8'd0, print_buf};
    endcase
  end

  p_irq_needs_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(plot_ie || print_ie));

  p_irq_has_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(xfer_done || xfer_err || cmd_done));

endmodule

// File: rtl/rpp_dma_ctrl.sv
module rpp_dma_ctrl
  import rpp_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int TMO_CYC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mem_req,
  output logic [17:0] mem_addr,
  input  logic        mem_gnt,
  input  logic [15:0] mem_rdata,
  input  logic        dev_ready,
  output logic        dev_strobe,
  output logic [7:0]  dev_data,
  output logic [1:0]  dev_mode,
  output logic [3:0]  dev_cmd,
  input  logic        dev_cmd_done,
  output logic        irq
);

  logic [7:0]       wr_en;
  logic             soft_rst;
  logic [15:0]      base_q, ext_q;
  logic [CNT_W-1:0] cnt_plot, cnt_print;
  logic             active, err, ready;
  mode_t            mode;
  logic             xfer_done, xfer_err;
  logic [3:0]       cmd_pend;
  logic             cmd_busy, cmd_done;
  logic             spp_sel;

  assign wr_en    = reg_wr ? (8'd1 << reg_addr) : 8'd0;
  assign soft_rst = wr_en[OFS_PLOT_CSR] && reg_wdata[1];
  assign ready    = !active && !cmd_busy;
  assign dev_mode = mode;

  rpp_dma_engine #(.CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .ld_base   (wr_en[OFS_BASE]),
    .ld_ext    (wr_en[OFS_ADDR_EXT]),
    .ld_plot   (wr_en[OFS_PLOT_CNT]),
    .ld_print  (wr_en[OFS_PRINT_CNT]),
    .wdata     (reg_wdata),
    .spp_sel   (spp_sel),
    .cmd_busy  (cmd_busy),
    .mem_gnt   (mem_gnt),
    .mem_rdata (mem_rdata),
    .dev_ready (dev_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .dev_strobe(dev_strobe),
    .dev_data  (dev_data),
    .base_q    (base_q),
    .ext_q     (ext_q),
    .cnt_plot  (cnt_plot),
    .cnt_print (cnt_print),
    .active    (active),
    .err       (err),
    .mode      (mode),
    .xfer_done (xfer_done),
    .xfer_err  (xfer_err)
  );

  rpp_cmd_unit u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .cmd_wr      (wr_en[OFS_PLOT_CSR]),
    .cmd_bits    (reg_wdata[5:2]),
    .allow       (!active),
    .dev_cmd_done(dev_cmd_done),
    .pend        (cmd_pend),
    .dev_cmd     (dev_cmd),
    .busy        (cmd_busy),
    .cmd_done    (cmd_done)
  );

  rpp_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_sel      (reg_addr),
    .wr_plot_csr (wr_en[OFS_PLOT_CSR]),
    .wr_print_csr(wr_en[OFS_PRINT_CSR]),
    .w_tcie      (reg_wdata[14]),
    .w_ie        (reg_wdata[6]),
    .w_spp       (reg_wdata[0]),
    .dev_strobe  (dev_strobe),
    .dev_data    (dev_data),
    .mode        (mode),
    .cnt_plot    (cnt_plot),
    .cnt_print   (cnt_print),
    .base_q      (base_q),
    .ext_q       (ext_q),
    .err         (err),
    .active      (active),
    .ready       (ready),
    .cmd_pend    (cmd_pend),
    .xfer_done   (xfer_done),
    .xfer_err    (xfer_err),
    .cmd_done    (cmd_done),
    .spp_sel     (spp_sel),
    .irq         (irq),
    .rdata       (reg_rdata)
  );

  p_ready_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_req);

  p_reset_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !mem_req && !active && (cmd_pend == 4'd0));

endmodule

// File: tb/tb_rpp_dma_ctrl.sv
module tb_rpp_dma_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mem_req;
  logic [17:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        dev_ready = 1'b1;
  logic        dev_strobe;
  logic [7:0]  dev_data;
  logic [1:0]  dev_mode;
  logic [3:0]  dev_cmd;
  logic        dev_cmd_done = 1'b0;
  logic        irq;

  rpp_dma_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .dev_ready(dev_ready), .dev_strobe(dev_strobe), .dev_data(dev_data),
    .dev_mode(dev_mode), .dev_cmd(dev_cmd), .dev_cmd_done(dev_cmd_done),
    .irq(irq)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  // observation state
  logic [7:0]  blog [0:63];
  int          bcnt = 0;
  logic [17:0] alog [0:15];
  int          acnt = 0;
  int          irq_cnt = 0;
  int          cmd_pulses = 0;
  logic [3:0]  cmd_last = '0;
  int          mem_lat = 2;
  bit          mem_dead = 0;
  bit          ready_toggle = 0;
  int          lat_cnt = 0;

  function automatic logic [15:0] memw(input logic [17:0] a);
    return {a[8:1] ^ 8'hA5, a[8:1] ^ 8'h3C};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [17:0] start, input int k);
    logic [15:0] w;
    w = memw(start + 18'(2 * (k / 2)));
    return (k % 2 == 1) ? w[15:8] : w[7:0];
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (dev_strobe && bcnt < 64) begin
        blog[bcnt] = dev_data;
        bcnt++;
      end
      if (irq) irq_cnt++;
      if (dev_cmd != 4'd0) begin
        cmd_pulses++;
        cmd_last = dev_cmd;
      end
      if (ready_toggle) dev_ready = ~dev_ready;
      if (mem_gnt) begin
        mem_gnt = 1'b0;
        lat_cnt = 0;
      end else if (mem_req && !mem_dead) begin
        if (lat_cnt >= mem_lat) begin
          mem_gnt = 1'b1;
          mem_rdata = memw(mem_addr);
          if (acnt < 16) alog[acnt] = mem_addr;
          acnt++;
          lat_cnt = 0;
        end else begin
          lat_cnt++;
        end
      end else begin
        lat_cnt = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd4, s);
      if (s[7]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_logs();
    bcnt = 0;
    acnt = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(3'd0, d); chk("R1 plot count", d, 16'h0000);
    rd(3'd2, d); chk("R1 print count", d, 16'h0000);
    rd(3'd4, d); chk("R1 plot status", d, 16'h0080);
    rd(3'd6, d); chk("R1 print status", d, 16'h0080);
    chk("R1 mem_req", mem_req, 1'b0);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_print_even();
    logic [15:0] d;
    int irq0;
    clear_logs();
    irq0 = irq_cnt;
    wr(3'd3, 16'h0100);
    wr(3'd1, 16'h0000);
    wr(3'd6, 16'h4040);
    wr(3'd2, 16'd6);
    chk("R2 print mode", dev_mode, 2'd0);
    rd(3'd6, d); chk("R2 active during transfer", {d[13], d[7]}, 2'b10);
    wait_idle();
    chk("R4 byte count even", bcnt, 6);
    for (int k = 0; k < 6; k++) chk("R4 print byte", blog[k], exp_byte(18'h00100, k));
    chk("R4 words fetched", acnt, 3);
    rd(3'd2, d); chk("R2 count zero after", d, 16'h0000);
    rd(3'd3, d); chk("R3 base advanced", d, 16'h0106);
    chk("R6 irq with both enables", irq_cnt - irq0, 1);
    rd(3'd7, d); chk("R11 print buffer", d, {8'h00, exp_byte(18'h00100, 5)});
  endtask

  task automatic t_plot_odd_stall();
    logic [15:0] d;
    int irq0;
    clear_logs();
    irq0 = irq_cnt;
    wr(3'd3, 16'h0200);
    wr(3'd4, 16'h0040);
    ready_toggle = 1;
    wr(3'd0, 16'd3);
    chk("R2 plot mode", dev_mode, 2'd1);
    wait_idle();
    ready_toggle = 0;
    dev_ready = 1'b1;
    chk("R5 stalled byte count", bcnt, 3);
    for (int k = 0; k < 3; k++) chk("R5 stalled byte", blog[k], exp_byte(18'h00200, k));
    chk("R4 odd count words", acnt, 2);
    chk("R6 no irq without completion enable", irq_cnt - irq0, 0);
    rd(3'd5, d); chk("R11 plot buffer", d, {8'h00, exp_byte(18'h00200, 2)});
  endtask

  task automatic t_combined();
    clear_logs();
    wr(3'd4, 16'h0001);
    wr(3'd6, 16'h0000);
    wr(3'd2, 16'd2);
    chk("R2 combined mode", dev_mode, 2'd2);
    wait_idle();
    chk("R2 combined bytes", bcnt, 2);
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_carry();
    logic [15:0] d;
    clear_logs();
    wr(3'd3, 16'hFFFE);
    wr(3'd1, 16'h0013);
    wr(3'd2, 16'd4);
    wait_idle();
    chk("R3 first address", alog[0], 18'h1FFFE);
    chk("R3 carried address", alog[1], 18'h20000);
    for (int k = 0; k < 4; k++) begin
      logic [17:0] a;
      a = (k < 2) ? 18'h1FFFE : 18'h20000;
      chk("R3 carry byte", blog[k], exp_byte(a, k % 2));
    end
    rd(3'd1, d); chk("R3 extension readback", d, 16'h0023);
    rd(3'd3, d); chk("R3 base readback", d, 16'h0002);
    wr(3'd7, 16'h00EE);
    rd(3'd7, d); chk("R11 buffer write ignored", d, {8'h00, exp_byte(18'h20000, 1)});
  endtask

  task automatic t_busy_and_reset();
    logic [15:0] d;
    int p0;
    clear_logs();
    p0 = cmd_pulses;
    wr(3'd3, 16'h0300);
    wr(3'd1, 16'h0000);
    dev_ready = 1'b0;
    wr(3'd2, 16'd4);
    repeat (8) @(negedge clk);
    wr(3'd0, 16'd5);
    rd(3'd0, d); chk("R2 count write while busy", d, 16'h0000);
    wr(3'd4, 16'h0010);
    chk("R9 command during transfer pulses", cmd_pulses - p0, 0);
    rd(3'd4, d); chk("R9 command during transfer readback", {d[13], d[5:2]}, 5'b10000);
    wr(3'd4, 16'h0002);
    rd(3'd4, d); chk("R10 status after reset", d, 16'h0080);
    rd(3'd2, d); chk("R10 print count cleared", d, 16'h0000);
    chk("R10 mem_req dropped", mem_req, 1'b0);
    dev_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 no bytes after abort", bcnt, 0);
  endtask

  task automatic t_command();
    logic [15:0] d;
    int p0, irq0, a0;
    p0 = cmd_pulses;
    irq0 = irq_cnt;
    a0 = acnt;
    wr(3'd4, 16'h0050);
    @(negedge clk);
    chk("R8 one pulse", cmd_pulses - p0, 1);
    chk("R8 form feed line", cmd_last, 4'b0100);
    rd(3'd4, d); chk("R8 pending readback", d, 16'h0050);
    wr(3'd2, 16'd2);
    rd(3'd2, d); chk("R2 count write during command", d, 16'h0000);
    chk("R2 no fetch during command", acnt - a0, 0);
    @(negedge clk);
    dev_cmd_done = 1'b1;
    @(negedge clk);
    dev_cmd_done = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd4, d); chk("R8 command cleared", d, 16'h00C0);
    chk("R8 command irq", irq_cnt - irq0, 1);
  endtask

  task automatic t_command_multi();
    logic [15:0] d;
    int p0, irq0;
    p0 = cmd_pulses;
    irq0 = irq_cnt;
    wr(3'd4, 16'h003C);
    @(negedge clk);
    chk("R9 single pulse", cmd_pulses - p0, 1);
    chk("R9 lowest command", cmd_last, 4'b0001);
    rd(3'd4, d); chk("R9 lowest readback", d, 16'h0004);
    dev_cmd_done = 1'b1;
    @(negedge clk);
    dev_cmd_done = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd4, d); chk("R9 done status", d, 16'h0080);
    chk("R8 no irq without enable", irq_cnt - irq0, 0);
  endtask

  task automatic t_timeout();
    logic [15:0] d;
    int irq0;
    irq0 = irq_cnt;
    mem_dead = 1;
    wr(3'd4, 16'h0040);
    wr(3'd0, 16'd2);
    repeat (40) @(negedge clk);
    rd(3'd4, d); chk("R7 still waiting at 40", {d[15], d[13]}, 2'b01);
    repeat (40) @(negedge clk);
    rd(3'd4, d); chk("R7 error set", d & 16'hA080, 16'h8080);
    chk("R7 error irq", irq_cnt - irq0, 1);
    chk("R7 request dropped", mem_req, 1'b0);
    mem_dead = 0;
    wr(3'd4, 16'h0002);
    rd(3'd4, d); chk("R10 error cleared", d, 16'h0080);
    rd(3'd0, d); chk("R10 plot count cleared", d, 16'h0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_print_even();
    t_plot_odd_stall();
    t_combined();
    t_carry();
    t_busy_and_reset();
    t_command();
    t_command_multi();
    t_timeout();
    finished = 1;
    summary();
    $finish;
  end

endmodule